// File: doc/BRIEF.md
# Receive Subaddress Ping-Pong Buffer Controller

This block holds one control and status word for each receive subaddress of a serial command/response bus remote terminal. For every accepted receive message it reports which of two data buffers (A or B) the message writes. It also reports whether the terminal must answer with Busy status and whether received data words may be stored. When alternation is active for a subaddress, the buffer choice flips after each clean message. The protocol engine sends one strobe when a command is decoded and another when the message finishes. The host sees each word through a simple register read/write port.

Alternation is governed by a handshake. The host raises a stop request to freeze the buffer choice so it can drain a buffer without collision. The block acknowledges by dropping its acknowledge bit, but only between messages. Clearing the stop request brings the acknowledge bit back. The block also keeps two flags per subaddress, one for activity and one for broadcast reception. It raises a broadcast interrupt request when both the per-subaddress enable and the global enable allow it. Commands to the broadcast address are dropped entirely when broadcast is disabled globally.

Top module: `rxsa_pingpong_ctrl`

## Requirements
- R1: When the block accepts a message it latches the subaddress's select bit: 0 selects buffer A and 1 selects buffer B. `msg_buf_b` shows that value from the cycle after `msg_start` until the end, and it stays stable throughout the message.
- R2: A message started while the mode is active (enable bit 0 set and acknowledge bit 8 set) that ends without error, is not illegal and was not answered Busy inverts the select bit when `msg_end` is accepted.
- R3: The select bit is unchanged after a message that ends with `msg_err`, after an illegal command, and after a message answered Busy.
- R4: Hardware reset (`rst_n` low) clears every word. Software reset (`soft_rst`) clears all device bits (8 to 11) and aborts any active message. It keeps the host bits 0 to 3. After either reset the first message uses buffer A.
- R5: The acknowledge bit (bit 8) takes the value of enable AND NOT stop-request (bit 1). It is updated one cycle after the host change, and only on cycles with no message active. While a message is active it holds.
- R6: With bit 0 set and bit 8 clear, each message reports the same buffer and the select bit does not toggle. The mode in force at message start decides the toggle, even if the acknowledge bit would change during the message.
- R7: With make-busy (bit 2) set, an accepted message shows `msg_busy`=1 and `msg_store`=0. Otherwise `msg_store`=1 unless the command is illegal.
- R8: The accessed flag (bit 10) is set when an accepted message ends. It is cleared by either reset and by a host read of that word. A read returns the value before the clear.
- R9: A valid, non-illegal broadcast command sets the broadcast flag (bit 11) at acceptance. A host read clears it. `bcast_irq` is 1 when any subaddress has bit 11 and its interrupt enable bit 3 both set, and `bcast_irq_en` is 1.
- R10: With `bcast_en`=0, a command with `msg_bcast`=1 is not accepted. `msg_active` stays 0 and no bit of any word changes.
- R11: With bit 0 clear, the select bit holds whatever the message outcome.
- R12: A host write changes only bits 0 to 3. Bits 8 to 11 are device-owned, and all other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, synchronously deasserted upstream |
| soft_rst | input | 1 | Synchronous software reset of device state |
| bcast_en | input | 1 | Global broadcast recognition enable |
| bcast_irq_en | input | 1 | Global broadcast interrupt enable |
| msg_start | input | 1 | Receive command decoded (one-cycle strobe) |
| msg_sa | input | SA_W | Subaddress of the command |
| msg_bcast | input | 1 | Command addressed to the broadcast address |
| msg_illegal | input | 1 | Command is illegal |
| msg_end | input | 1 | Message finished (one-cycle strobe) |
| msg_err | input | 1 | Message ended in error (with msg_end) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (clears flags at the clock edge) |
| host_addr | input | SA_W | Subaddress word selected by the host |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected word, combinational |
| msg_active | output | 1 | A message is in progress |
| msg_buf_b | output | 1 | Buffer for the active message: 0 = A, 1 = B |
| msg_busy | output | 1 | Answer the active message with Busy |
| msg_store | output | 1 | Data words of the active message may be stored |
| bcast_irq | output | 1 | Broadcast interrupt request |

## Verification
The bench builds the block with four subaddresses (SA_W=2), so every word can be read back after every message. It sweeps every subaddress over each combination of enable, stop request and make-busy, and over clean, errored and illegal outcomes. A running model of all four words predicts each buffer choice and each flag. Further sequences cover a stop request raised during a message, software reset with both buffers in use, and every combination of the three broadcast enables.

// File: rtl/rxsa_pkg.sv
package rxsa_pkg;
  localparam int CW_W   = 16;
  localparam int B_PPEN = 0;
  localparam int B_STOP = 1;
  localparam int B_BUSY = 2;
  localparam int B_BCIE = 3;
  localparam int B_ACK  = 8;
  localparam int B_SEL  = 9;
  localparam int B_ACC  = 10;
  localparam int B_BC   = 11;

  typedef struct packed {
    logic bc_ie;
    logic mk_busy;
    logic stop_req;
    logic pp_en;
  } sa_cfg_t;

  typedef struct packed {
    logic bc_seen;
    logic accessed;
    logic sel_b;
    logic pp_ack;
  } sa_stat_t;

  function automatic logic [CW_W-1:0] pack_word(sa_cfg_t c, sa_stat_t s);
    logic [CW_W-1:0] w;
    w         = '0;
    w[B_PPEN] = c.pp_en;
    w[B_STOP] = c.stop_req;
    w[B_BUSY] = c.mk_busy;
    w[B_BCIE] = c.bc_ie;
    w[B_ACK]  = s.pp_ack;
    w[B_SEL]  = s.sel_b;
    w[B_ACC]  = s.accessed;
    w[B_BC]   = s.bc_seen;
    return w;
  endfunction

  function automatic sa_cfg_t unpack_cfg(logic [CW_W-1:0] w);
    sa_cfg_t c;
    c.pp_en    = w[B_PPEN];
    c.stop_req = w[B_STOP];
    c.mk_busy  = w[B_BUSY];
    c.bc_ie    = w[B_BCIE];
    return c;
  endfunction
endpackage

// File: rtl/rxsa_msg_trk.sv
module rxsa_msg_trk
  import rxsa_pkg::*;
#(
  parameter int SA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            bcast_en,
  input  logic            msg_start,
  input  logic [SA_W-1:0] msg_sa,
  input  logic            msg_bcast,
  input  logic            msg_illegal,
  input  logic            msg_end,
  input  logic            msg_err,
  input  logic            sa_mode,
  input  logic            sa_busy,
  input  logic            sa_sel,
  output logic            accept,
  output logic            accept_bc,
  output logic            done,
  output logic            done_toggle,
  output logic            act,
  output logic [SA_W-1:0] act_sa,
  output logic            act_sel,
  output logic            act_busy,
  output logic            act_ill
);
  logic            act_q, act_d;
  logic [SA_W-1:0] sa_q, sa_d;
  logic            pp_q, pp_d;
  logic            busy_q, busy_d;
  logic            ill_q, ill_d;
  logic            sel_q, sel_d;
  logic            ctx_en;

  // Acceptance and completion decode
  always_comb begin
    accept      = msg_start && !act_q && !soft_rst && !(msg_bcast && !bcast_en);
    accept_bc   = accept && msg_bcast && !msg_illegal;
    done        = msg_end && act_q && !soft_rst;
    done_toggle = done && pp_q && !msg_err && !busy_q && !ill_q;
  end

  // Next-state for the message context
  always_comb begin
    act_d  = act_q;
    sa_d   = sa_q;
    pp_d   = pp_q;
    busy_d = busy_q;
    ill_d  = ill_q;
    sel_d  = sel_q;
    ctx_en = accept;
    if (soft_rst) begin
      act_d = 1'b0;
    end else if (accept) begin
      act_d  = 1'b1;
      sa_d   = msg_sa;
      pp_d   = sa_mode;
      busy_d = sa_busy;
      ill_d  = msg_illegal;
      sel_d  = sa_sel;
    end else if (done) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q   <= '0;
      pp_q   <= 1'b0;
      busy_q <= 1'b0;
      ill_q  <= 1'b0;
      sel_q  <= 1'b0;
    end else if (ctx_en) begin
      sa_q   <= sa_d;
      pp_q   <= pp_d;
      busy_q <= busy_d;
      ill_q  <= ill_d;
      sel_q  <= sel_d;
    end
  end

  assign act      = act_q;
  assign act_sa   = sa_q;
  assign act_sel  = sel_q;
  assign act_busy = busy_q;
  assign act_ill  = ill_q;
endmodule

// File: rtl/rxsa_slot.sv
module rxsa_slot
  import rxsa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     idle,
  input  logic     wr_en,
  input  sa_cfg_t  wr_cfg,
  input  logic     rd_en,
  input  logic     set_bc,
  input  logic     set_acc,
  input  logic     toggle,
  output sa_cfg_t  cfg,
  output sa_stat_t stat
);
  sa_cfg_t  cfg_q, cfg_d;
  sa_stat_t st_q, st_d;
  logic     cfg_en;

  // Host-owned bits: write only
  always_comb begin
    cfg_en = wr_en;
    cfg_d  = wr_cfg;
  end

  // Device-owned bits
  always_comb begin
    st_d = st_q;
    if (soft_rst) begin
      st_d = '0;
    end else begin
      if (idle) st_d.pp_ack = cfg_q.pp_en && !cfg_q.stop_req;
      if (toggle) st_d.sel_b = !st_q.sel_b;
      if (rd_en) begin
        st_d.accessed = 1'b0;
        st_d.bc_seen  = 1'b0;
      end
      if (set_acc) st_d.accessed = 1'b1;
      if (set_bc)  st_d.bc_seen  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign cfg  = cfg_q;
  assign stat = st_q;
endmodule

// File: rtl/rxsa_pingpong_ctrl.sv
module rxsa_pingpong_ctrl
  import rxsa_pkg::*;
#(
  parameter int SA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            bcast_en,
  input  logic            bcast_irq_en,
  input  logic            msg_start,
  input  logic [SA_W-1:0] msg_sa,
  input  logic            msg_bcast,
  input  logic            msg_illegal,
  input  logic            msg_end,
  input  logic            msg_err,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [SA_W-1:0] host_addr,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  output logic            msg_active,
  output logic            msg_buf_b,
  output logic            msg_busy,
  output logic            msg_store,
  output logic            bcast_irq
);
  localparam int NUM_SA = 1 << SA_W;

  sa_cfg_t  cfg_a  [NUM_SA];
  sa_stat_t stat_a [NUM_SA];

  logic [NUM_SA-1:0] mode_vec;
  logic [NUM_SA-1:0] busy_vec;
  logic [NUM_SA-1:0] sel_vec;
  logic [NUM_SA-1:0] ack_vec;
  logic [NUM_SA-1:0] bc_vec;
  logic [NUM_SA-1:0] irq_vec;

  logic            accept, accept_bc, done, done_toggle;
  logic            act, act_sel, act_busy, act_ill;
  logic [SA_W-1:0] act_sa;
  sa_cfg_t         wr_cfg;
  logic            unused_wbits;

  assign wr_cfg       = unpack_cfg(host_wdata);
  assign unused_wbits = ^host_wdata[15:4];

  rxsa_msg_trk #(.SA_W(SA_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .bcast_en   (bcast_en),
    .msg_start  (msg_start),
    .msg_sa     (msg_sa),
    .msg_bcast  (msg_bcast),
    .msg_illegal(msg_illegal),
    .msg_end    (msg_end),
    .msg_err    (msg_err),
    .sa_mode    (mode_vec[msg_sa]),
    .sa_busy    (busy_vec[msg_sa]),
    .sa_sel     (sel_vec[msg_sa]),
    .accept     (accept),
    .accept_bc  (accept_bc),
    .done       (done),
    .done_toggle(done_toggle),
    .act        (act),
    .act_sa     (act_sa),
    .act_sel    (act_sel),
    .act_busy   (act_busy),
    .act_ill    (act_ill)
  );

  for (genvar i = 0; i < NUM_SA; i++) begin : g_slot
    logic hit_w, hit_r, hit_s, hit_e;
    assign hit_w = host_wr && (host_addr == SA_W'(i));
    assign hit_r = host_rd && (host_addr == SA_W'(i));
    assign hit_s = accept_bc && (msg_sa == SA_W'(i));
    assign hit_e = done && (act_sa == SA_W'(i));

    rxsa_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .idle    (!act),
      .wr_en   (hit_w),
      .wr_cfg  (wr_cfg),
      .rd_en   (hit_r),
      .set_bc  (hit_s),
      .set_acc (hit_e),
      .toggle  (hit_e && done_toggle),
      .cfg     (cfg_a[i]),
      .stat    (stat_a[i])
    );

    assign mode_vec[i] = cfg_a[i].pp_en && stat_a[i].pp_ack;
    assign busy_vec[i] = cfg_a[i].mk_busy;
    assign sel_vec[i]  = stat_a[i].sel_b;
    assign ack_vec[i]  = stat_a[i].pp_ack;
    assign bc_vec[i]   = stat_a[i].bc_seen;
    assign irq_vec[i]  = stat_a[i].bc_seen && cfg_a[i].bc_ie;
  end

  always_comb begin
    host_rdata = '0;
    for (int k = 0; k < NUM_SA; k++) begin
      if (host_addr == SA_W'(k)) host_rdata = pack_word(cfg_a[k], stat_a[k]);
    end
  end

  assign msg_active = act;
  assign msg_buf_b  = act_sel;
  assign msg_busy   = act && act_busy;
  assign msg_store  = act && !act_busy && !act_ill;
  assign bcast_irq  = bcast_irq_en && (|irq_vec);
endmodule

// File: rtl/rxsa_pingpong_chk.sv
module rxsa_pingpong_chk #(
  parameter int NUM_SA = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              msg_start,
  input logic              msg_bcast,
  input logic              bcast_en,
  input logic              msg_active,
  input logic              msg_buf_b,
  input logic              done,
  input logic [NUM_SA-1:0] sel_vec,
  input logic [NUM_SA-1:0] ack_vec,
  input logic [NUM_SA-1:0] bc_vec
);
  // R1
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_active && $past(msg_active) |-> $stable(msg_buf_b));

  // R5
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_active && $past(msg_active) |-> $stable(ack_vec));

  // R2
  sel_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) && !$past(soft_rst) |-> $stable(sel_vec));

  // R4
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (sel_vec == '0) && (bc_vec == '0) && !msg_active);

  // R10
  bc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_vec & ~$past(bc_vec)) != '0 |-> $past(msg_start && msg_bcast && bcast_en));
endmodule

bind rxsa_pingpong_ctrl rxsa_pingpong_chk #(.NUM_SA(NUM_SA)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .msg_start (msg_start),
  .msg_bcast (msg_bcast),
  .bcast_en  (bcast_en),
  .msg_active(msg_active),
  .msg_buf_b (msg_buf_b),
  .done      (done),
  .sel_vec   (sel_vec),
  .ack_vec   (ack_vec),
  .bc_vec    (bc_vec)
);

// File: tb/rxsa_pingpong_ctrl_bench.sv
module rxsa_pingpong_ctrl_bench;
  localparam int SA_W = 2;
  localparam int NSA  = 1 << SA_W;

  logic clk, rst_n, soft_rst, bcast_en, bcast_irq_en;
  logic msg_start, msg_bcast, msg_illegal, msg_end, msg_err;
  logic [SA_W-1:0] msg_sa, host_addr;
  logic host_wr, host_rd;
  logic [15:0] host_wdata, host_rdata;
  logic msg_active, msg_buf_b, msg_busy, msg_store, bcast_irq;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // model: cfg bits {ie,busy,stop,pp}, device bits
  logic [3:0] m_cfg [NSA];
  logic       m_ack [NSA];
  logic       m_sel [NSA];
  logic       m_acc [NSA];
  logic       m_bc  [NSA];

  rxsa_pingpong_ctrl #(.SA_W(SA_W)) u_rxsa_pingpong_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bcast_en(bcast_en),
    .bcast_irq_en(bcast_irq_en), .msg_start(msg_start), .msg_sa(msg_sa),
    .msg_bcast(msg_bcast), .msg_illegal(msg_illegal), .msg_end(msg_end),
    .msg_err(msg_err), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .msg_active(msg_active), .msg_buf_b(msg_buf_b), .msg_busy(msg_busy),
    .msg_store(msg_store), .bcast_irq(bcast_irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] exp_word(int s);
    logic [15:0] w;
    w = '0;
    w[3:0] = m_cfg[s];
    w[8]   = m_ack[s];
    w[9]   = m_sel[s];
    w[10]  = m_acc[s];
    w[11]  = m_bc[s];
    return w;
  endfunction

  task automatic idle_acks();
    for (int s = 0; s < NSA; s++) m_ack[s] = m_cfg[s][0] & ~m_cfg[s][1];
  endtask

  // write then one idle cycle so the acknowledge settles (R5)
  task automatic hwrite(input int s, input logic [15:0] v);
    host_addr = SA_W'(s); host_wdata = v; host_wr = 1;
    tick();
    host_wr = 0;
    m_cfg[s] = v[3:0];
    tick();
    idle_acks();
  endtask

  task automatic hread(input int s, input string req);
    host_addr = SA_W'(s); host_rd = 1;
    #1;
    chk(req, host_rdata, exp_word(s));
    tick();
    host_rd = 0;
    m_acc[s] = 0; m_bc[s] = 0;
    idle_acks();
  endtask

  task automatic run_msg(input int s, input bit bc, input bit ill, input bit err);
    bit valid, mode;
    valid = !(bc && !bcast_en);
    mode  = m_cfg[s][0] & m_ack[s];
    msg_sa = SA_W'(s); msg_bcast = bc; msg_illegal = ill; msg_start = 1;
    tick();
    msg_start = 0; msg_bcast = 0; msg_illegal = 0;
    if (valid) begin
      chk("R1 active", 16'(msg_active), 16'd1);
      chk("R1 buffer", 16'(msg_buf_b), 16'(m_sel[s]));
      chk("R7 busy", 16'(msg_busy), 16'(m_cfg[s][2]));
      chk("R7 store", 16'(msg_store), 16'(!m_cfg[s][2] && !ill));
      if (bc && !ill) m_bc[s] = 1;
    end else begin
      chk("R10 not accepted", 16'(msg_active), 16'd0);
    end
    tick();
    msg_end = 1; msg_err = err;
    tick();
    msg_end = 0; msg_err = 0;
    if (valid) begin
      m_acc[s] = 1;
      if (mode && !err && !m_cfg[s][2] && !ill) m_sel[s] = !m_sel[s];
    end
    chk("R1 ended", 16'(msg_active), 16'd0);
    tick();
    idle_acks();
  endtask

  initial begin
    rst_n = 0; soft_rst = 0; bcast_en = 0; bcast_irq_en = 0;
    msg_start = 0; msg_bcast = 0; msg_illegal = 0; msg_end = 0; msg_err = 0;
    msg_sa = '0; host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    for (int s = 0; s < NSA; s++) begin
      m_cfg[s] = 0; m_ack[s] = 0; m_sel[s] = 0; m_acc[s] = 0; m_bc[s] = 0;
    end
    tick(); tick();
    rst_n = 1;
    tick();

    // R4 reset state
    chk("R4 reset active", 16'(msg_active), 16'd0);
    chk("R4 reset irq", 16'(bcast_irq), 16'd0);
    for (int s = 0; s < NSA; s++) hread(s, "R4 reset word");

    // R12 device bits not writable
    for (int s = 0; s < NSA; s++) begin
      hwrite(s, 16'hFFFF);
      hread(s, "R12 write mask");
      hwrite(s, 16'h0000);
    end

    // Near-exhaustive sweep: R2 R3 R5 R6 R7 R8 R11
    for (int s = 0; s < NSA; s++)
      for (int c = 0; c < 8; c++)
        for (int o = 0; o < 3; o++) begin
          hwrite(s, 16'(c));
          run_msg(s, 0, o == 2, o == 1);
          for (int r = 0; r < NSA; r++) hread(r, "R2 R3 R6 R11 word after message");
          hread(s, "R8 accessed cleared by read");
        end

    // R6: stop request raised mid-message; mode latched at start
    hwrite(1, 16'h0001);
    begin
      bit sel0;
      sel0 = m_sel[1];
      msg_sa = 2'd1; msg_start = 1;
      tick();
      msg_start = 0;
      host_addr = 2'd1; host_wdata = 16'h0003; host_wr = 1;
      tick();
      host_wr = 0; m_cfg[1] = 4'h3;
      tick();
      chk("R5 ack held during message", 16'(host_rdata[8]), 16'd1);
      msg_end = 1;
      tick();
      msg_end = 0;
      chk("R6 mode latched toggles", 16'(host_rdata[9]), 16'(!sel0));
      tick();
      chk("R5 ack drops when idle", 16'(host_rdata[8]), 16'd0);
      m_sel[1] = !sel0; m_acc[1] = 1; idle_acks();
      hread(1, "R6 word after latched message");
      run_msg(1, 0, 0, 0);
      hread(1, "R6 no toggle while stopped");
      hwrite(1, 16'h0001);
      hread(1, "R5 ack back after stop cleared");
    end

    // R9 R10 broadcast sweep on subaddress 3
    for (int be = 0; be < 2; be++)
      for (int gi = 0; gi < 2; gi++)
        for (int ie = 0; ie < 2; ie++) begin
          bcast_en = be[0]; bcast_irq_en = gi[0];
          hwrite(3, 16'(ie << 3));
          run_msg(3, 1, 0, 0);
          chk("R9 irq", 16'(bcast_irq), 16'(be[0] & gi[0] & ie[0]));
          for (int r = 0; r < NSA; r++) hread(r, "R9 R10 words after broadcast");
          chk("R9 irq cleared by read", 16'(bcast_irq), 16'd0);
        end
    bcast_en = 1; bcast_irq_en = 1;
    hwrite(3, 16'h0008);
    run_msg(3, 1, 1, 0);
    chk("R9 illegal broadcast no irq", 16'(bcast_irq), 16'd0);
    hread(3, "R9 illegal broadcast flag");

    // R4 soft reset with mixed select bits
    hwrite(0, 16'h0001);
    run_msg(0, 0, 0, 0);
    hwrite(2, 16'h0001);
    run_msg(2, 0, 0, 0);
    soft_rst = 1;
    tick();
    soft_rst = 0;
    for (int s = 0; s < NSA; s++) begin
      m_sel[s] = 0; m_acc[s] = 0; m_bc[s] = 0; m_ack[s] = 0;
    end
    host_addr = 2'd0;
    #1;
    chk("R4 soft reset word", host_rdata, exp_word(0));
    tick();
    idle_acks();
    for (int s = 0; s < NSA; s++) hread(s, "R4 soft reset keeps host bits");
    run_msg(0, 0, 0, 0);
    hread(0, "R4 first message after reset used A");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule